// File: doc/BRIEF.md
# Protected Clock Prescaler Register

This block holds the division setting for a system clock and turns it into a clock-enable pulse. Software reaches one 8-bit control register on a simple register bus. The top bit is a change-enable flag. The low nibble selects a power-of-two division factor. The bits in between always read zero.

The divide setting cannot be changed by a single stray write. Software must first write a value with only the top bit set. This arms the change-enable flag, which then stays armed for a window of four clock cycles. Within that window, one write with the top bit clear loads the new select value and disarms the flag at once. Once the window ends, the flag clears by itself. Writing the flag again while it is armed has no effect on it.

A strap input chooses the select value loaded at reset: divide by 1 or divide by 8. The divider output is a one-cycle enable pulse, not a gated clock.

Top module: `clk_prescale_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the select field holds 0011 if `strap_div8` is 1 and 0000 if it is 0, and the change-enable flag is 0.
- R2: A read at address 0x26 returns the change-enable flag in bit 7, zeros in bits 6 to 4 and the select field in bits 3 to 0. Any other address reads as 0x00.
- R3: A write to address 0x26 arms the change-enable flag only if the data is exactly 0x80. A write with bit 7 set and any of bits 6 to 0 set leaves the flag clear. Writes to other addresses have no effect.
- R4: While the flag is armed, a write to 0x26 with bit 7 clear loads bits 3 to 0 into the select field, whatever the strap setting, and clears the flag in the same cycle.
- R5: An armed flag accepts a select write on any of the four clock edges that follow the arming edge. It is clear after the fourth edge, so a select write on the fifth edge is ignored.
- R6: A write with bit 7 set while the flag is armed neither restarts the four-cycle window, nor clears the flag, nor changes the select field.
- R7: A write with bit 7 clear while the flag is not armed leaves the select field and the enable pulse pattern unchanged.
- R8: Select code k from 0 to 8 divides by 2^k: `clk_en` is high for one cycle in every 2^k cycles, and is high in every cycle for code 0. Codes 9 to 15 divide by 1.
- R9: Each accepted select write restarts the divider. The first pulse at the new factor N comes in the N-th cycle after the write edge, and after reset the first pulse comes in the N-th cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| strap_div8 | input | 1 | Reset strap: 1 selects divide by 8 at reset |
| bus_addr | input | 6 | Register bus address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| clk_en | output | 1 | One-cycle clock-enable pulse at the divided rate |

## Verification
The bench probes the edges of the unlock window. It writes a select value on exactly the fourth edge after arming, which must be accepted, and on the fifth edge, which must be ignored. A window that is one cycle short or long shows up as a wrong select read-back and a wrong pulse rate. It also re-writes the flag in the middle of the window and then writes on the edge just past the original deadline. A design that restarts the timer on that re-write would wrongly accept the late write. The bench sends writes that have bit 7 set together with other bits, which must not arm the flag, and writes to a neighbouring address, which must change nothing. It steps through all sixteen select codes and compares the pulse position on every cycle, so a divider that is not restarted cleanly or that mishandles the reserved codes gives an early, late or missing pulse.

// File: rtl/clk_prescale_pkg.sv
package clk_prescale_pkg;

    localparam int DATA_W   = 8;
    localparam int SEL_W    = 4;
    localparam int MAX_LOG2 = 8;
    localparam int CNT_W    = MAX_LOG2;

    // register image as seen on the bus
    typedef struct packed {
        logic             armed;
        logic [2:0]       zero;
        logic [SEL_W-1:0] sel;
    } ctl_view_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_ARM,
        WR_LOAD,
        WR_DROP
    } wr_kind_e;

    // terminal count for a select code; reserved codes fall back to divide by 1
    function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] code);
        int unsigned n;
        if (int'(code) <= MAX_LOG2) n = (1 << code) - 1;
        else                        n = 0;
        return CNT_W'(n);
    endfunction

    // decide what a register write does given the current flag
    function automatic wr_kind_e classify(input logic [DATA_W-1:0] d, input logic armed);
        if (d[DATA_W-1]) begin
            if (!armed && d[DATA_W-2:0] == '0) return WR_ARM;
            return WR_DROP;
        end
        if (armed) return WR_LOAD;
        return WR_DROP;
    endfunction

endpackage

// File: rtl/clk_prescale_guard.sv
module clk_prescale_guard
    import clk_prescale_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_div8,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic              armed_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              load_o
);
    localparam int TMR_W = $clog2(WINDOW + 1);
    localparam logic [SEL_W-1:0] SEL_DIV8 = SEL_W'(3);

    logic             armed_q;
    logic [TMR_W-1:0] tmr_q;
    logic [SEL_W-1:0] sel_q;
    wr_kind_e         kind;

    always_comb begin
        kind = WR_NONE;
        if (wr_hit) kind = classify(wr_data, armed_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            tmr_q   <= '0;
            sel_q   <= strap_div8 ? SEL_DIV8 : '0;
        end else begin
            case (kind)
                WR_ARM: begin
                    armed_q <= 1'b1;
                    tmr_q   <= TMR_W'(WINDOW);
                end
                WR_LOAD: begin
                    sel_q   <= wr_data[SEL_W-1:0];
                    armed_q <= 1'b0;
                    tmr_q   <= '0;
                end
                default: begin
                    if (armed_q) begin
                        if (tmr_q == TMR_W'(1)) begin
                            armed_q <= 1'b0;
                            tmr_q   <= '0;
                        end else begin
                            tmr_q <= tmr_q - TMR_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign armed_o = armed_q;
    assign sel_o   = sel_q;
    assign load_o  = (kind == WR_LOAD);

endmodule

// File: rtl/clk_prescale_divider.sv
module clk_prescale_divider
    import clk_prescale_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = div_last(sel);
    assign tick = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/clk_prescale_ctl.sv
module clk_prescale_ctl
    import clk_prescale_pkg::*;
#(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(6'h26),
    parameter int                WINDOW   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strap_div8,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_en
);
    logic             hit;
    logic             pend_q;
    logic [SEL_W-1:0] sel_q;
    logic             sel_load;
    ctl_view_t        view;

    assign hit = (bus_addr == REG_ADDR);

    clk_prescale_guard #(.WINDOW(WINDOW)) u_guard (
        .clk        (clk),
        .rst        (rst),
        .strap_div8 (strap_div8),
        .wr_hit     (hit && bus_we),
        .wr_data    (bus_wdata),
        .armed_o    (pend_q),
        .sel_o      (sel_q),
        .load_o     (sel_load)
    );

    clk_prescale_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel_q),
        .restart (sel_load),
        .tick    (clk_en)
    );

    always_comb begin
        view.armed = pend_q;
        view.zero  = '0;
        view.sel   = sel_q;
    end

    assign bus_rdata = hit ? DATA_W'(view) : '0;

endmodule

// File: rtl/clk_prescale_ctl_chk.sv
module clk_prescale_ctl_chk #(
    parameter int                ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(6'h26),
    parameter int                WINDOW   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              clk_en,
    input logic              pend_q,
    input logic [3:0]        sel_q
);
    int unsigned armed_run;

    always_ff @(posedge clk) begin
        if (rst)         armed_run <= 0;
        else if (pend_q) armed_run <= armed_run + 1;
        else             armed_run <= 0;
    end

    // R2
    foreign_addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));

    // R2
    reserved_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[6:4] == 3'b000);

    // R3
    bad_arm_rejected_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && bus_we && bus_addr == REG_ADDR && bus_wdata[7] && bus_wdata[6:0] != 7'd0)
        |=> !pend_q);

    // R4
    unlocked_load_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && bus_we && bus_addr == REG_ADDR && !bus_wdata[7])
        |=> (!pend_q && sel_q == $past(bus_wdata[3:0])));

    // R5
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        armed_run <= WINDOW);

    // R7
    locked_select_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q |=> (sel_q == $past(sel_q)));

    // R8
    unity_divide_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_q == 4'd0) |-> clk_en);

endmodule

bind clk_prescale_ctl clk_prescale_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .WINDOW   (WINDOW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clk_en    (clk_en),
    .pend_q    (pend_q),
    .sel_q     (sel_q)
);

// File: tb/test_clk_prescale_ctl.sv
module test_clk_prescale_ctl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strap_div8 = 1'b1;
    logic [5:0] bus_addr = 6'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       clk_en;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // behavioural reference state
    int m_sel = 3;
    bit m_pend = 1'b0;
    int m_left = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    clk_prescale_ctl i_clk_prescale_ctl (
        .clk        (clk),
        .rst        (rst),
        .strap_div8 (strap_div8),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .clk_en     (clk_en)
    );

    function automatic int factor(input int s);
        if (s <= 8) return 1 << s;
        return 1;
    endfunction

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        bit load;
        load = 1'b0;
        if (rst) begin
            m_sel  = strap_div8 ? 3 : 0;
            m_pend = 1'b0;
            m_left = 0;
            m_cnt  = 0;
        end else begin
            if (bus_we && bus_addr == 6'h26 && bus_wdata == 8'h80 && !m_pend) begin
                m_pend = 1'b1;
                m_left = 4;
            end else if (bus_we && bus_addr == 6'h26 && !bus_wdata[7] && m_pend) begin
                m_sel  = int'(bus_wdata[3:0]);
                m_pend = 1'b0;
                m_left = 0;
                load   = 1'b1;
            end else if (m_pend) begin
                m_left = m_left - 1;
                if (m_left == 0) m_pend = 1'b0;
            end
            if (load)                            m_cnt = 0;
            else if (m_cnt == factor(m_sel) - 1) m_cnt = 0;
            else                                 m_cnt = m_cnt + 1;
        end
    end

    // compare after the edge has settled
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [7:0] exp_rd;
            logic       exp_en;
            exp_en = (m_cnt == factor(m_sel) - 1);
            exp_rd = (bus_addr == 6'h26) ? {m_pend, 3'b000, 4'(m_sel)} : 8'h00;
            checks++;
            if (clk_en !== exp_en) begin
                errors++;
                $display("FAIL %s clk_en: got %0b expected %0b at %0t", cur_req, clk_en, exp_en, $time);
            end
            checks++;
            if (bus_rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s bus_rdata: got %02h expected %02h at %0t", cur_req, bus_rdata, exp_rd, $time);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 6'h26;
        bus_wdata = 8'h00;
    endtask

    // like wr, but the write is one cycle later than the previous one
    task automatic wr_next(input logic [5:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 6'h26;
        bus_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic direct_check(input string req, input logic [7:0] exp);
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s readback: got %02h expected %02h", req, bus_rdata, exp);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        strap_div8 = strap;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bus_addr = 6'h26;
        // R1: strap active, divide by 8
        cur_req = "R1";
        do_reset(1'b1);
        direct_check("R1", 8'h03);
        idle(24);

        // R7: select write with no unlock
        cur_req = "R7";
        wr(6'h26, 8'h05);
        direct_check("R7", 8'h03);
        idle(16);

        // R3: bad arm patterns and wrong address
        cur_req = "R3";
        wr(6'h26, 8'h81);
        direct_check("R3", 8'h03);
        wr(6'h26, 8'h05);
        wr(6'h26, 8'hF0);
        wr(6'h25, 8'h80);
        wr(6'h26, 8'h05);
        direct_check("R3", 8'h03);
        // R2: other address reads zero
        cur_req = "R2";
        @(negedge clk);
        bus_addr = 6'h27;
        idle(2);
        bus_addr = 6'h26;
        idle(4);

        // R4: immediate select after arm
        cur_req = "R4";
        wr(6'h26, 8'h80);
        direct_check("R4", 8'h83);
        wr_next(6'h26, 8'h02);
        direct_check("R4", 8'h02);
        idle(12);

        // R5: write on fourth edge accepted
        cur_req = "R5";
        wr(6'h26, 8'h80);
        idle(3);
        wr_next(6'h26, 8'h01);
        direct_check("R5", 8'h01);
        idle(8);
        // R5: write on fifth edge ignored
        wr(6'h26, 8'h80);
        idle(4);
        wr_next(6'h26, 8'h04);
        direct_check("R5", 8'h01);
        idle(8);

        // R6: re-arm mid window does not extend or clear
        cur_req = "R6";
        wr(6'h26, 8'h80);
        wr_next(6'h26, 8'h80);
        direct_check("R6", 8'h81);
        wr_next(6'h26, 8'h85);
        direct_check("R6", 8'h81);
        idle(1);
        wr_next(6'h26, 8'h03);
        direct_check("R6", 8'h03);
        idle(10);
        wr(6'h26, 8'h80);
        idle(2);
        wr_next(6'h26, 8'h80);
        idle(1);
        wr_next(6'h26, 8'h06);
        direct_check("R6", 8'h03);
        idle(10);

        // R8 and R9: every code, restart on each load
        for (int k = 0; k < 16; k++) begin
            cur_req = (k > 8) ? "R8" : "R9";
            wr(6'h26, 8'h80);
            wr_next(6'h26, 8'(k));
            idle((k <= 8) ? (3 * (1 << k) + 5) : 12);
        end
        // R9: reload same code mid-count restarts
        cur_req = "R9";
        wr(6'h26, 8'h80);
        wr_next(6'h26, 8'h04);
        idle(7);
        wr(6'h26, 8'h80);
        wr_next(6'h26, 8'h04);
        idle(40);

        // R1: strap inactive gives divide by 1; R4: any value regardless of strap
        cur_req = "R1";
        do_reset(1'b0);
        direct_check("R1", 8'h00);
        idle(6);
        cur_req = "R4";
        wr(6'h26, 8'h80);
        wr_next(6'h26, 8'h03);
        direct_check("R4", 8'h03);
        idle(20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule